// File: doc/BRIEF.md
# High-Bandwidth Isochronous IN Microframe Sequencer

This block runs the host side of one high-speed isochronous IN endpoint that may move up to three packets in a single microframe. The endpoint's 16-bit max-packet setting is split into two parts: a per-packet payload limit and the number of packets allowed per microframe. At each microframe start strobe the block asks the token generator for an IN token. It then judges each data packet that comes back and decides whether to request another token before the microframe ends.

The endpoint uses the data PID of its first packet to say how many packets it will send. DATA2 means three, DATA1 means two and DATA0 means one. Each later packet must carry the next lower PID. The sequence stops at DATA0, at a short packet, or at the first bad response. Nothing is retried. The next microframe strobe starts the sequence again from the top.

Token requests use a valid/ready stream. `token_valid` stays high, and the request stays unchanged, until `token_ready` is sampled high. One handshake equals one token. The response side has no back-pressure, because a packet on the bus cannot be stalled. A `resp_valid` pulse is evaluated only while a token is outstanding and is ignored at any other time. Packet framing and CRC checking happen upstream. They reach this block only as `resp_err`.

Top module: `iso_in_uframe_seq`

## Requirements
- R1: `mps_cfg[10:0]` is the payload limit in bytes and `mps_cfg[12:11]`+1 is the packet count per microframe. `cfg_err` is high while any of `mps_cfg[15:13]` is set, while the payload limit is zero, or while `mps_cfg[12:11]` equals 3. A microframe strobe given while `cfg_err` is high issues no token.
- R2: A `uframe_start` pulse with a valid setting raises `token_valid` from the next cycle. This also happens in the middle of a running sequence, and the next response is then judged as a first response.
- R3: `token_valid` stays high until `token_ready` is sampled high. A `resp_valid` received while no token is outstanding gives neither accept nor reject.
- R4: The 2-bit response PID code is 0 for DATA0, 1 for DATA1, 2 for DATA2 and 3 for MDATA. A first response is accepted only when its code is below the configured count. MDATA, or a code that implies more packets than configured, is rejected.
- R5: After the first response, each response must carry the code one below the previous accepted code. Any other code is rejected.
- R6: A response with `resp_err` high, or with `resp_len` above the payload limit, is rejected.
- R7: An accepted DATA0 pulses `uframe_done` and no further token is requested.
- R8: An accepted response with `resp_len` below the payload limit pulses `uframe_done` and no further token is requested, whatever its PID.
- R9: An accepted full-size response with a nonzero code raises `token_valid` in the cycle after the response, with no `uframe_done`.
- R10: A rejected response pulses `uframe_done` together with `txn_reject`. No token follows until the next microframe strobe.
- R11: `txn_accept`, `txn_reject` and `uframe_done` are one-cycle pulses in the cycle after the response. During and right after reset, `token_valid` and all three pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mps_cfg | input | 16 | Endpoint max-packet setting |
| uframe_start | input | 1 | Microframe start strobe |
| token_valid | output | 1 | IN token request |
| token_ready | input | 1 | Token generator takes the request |
| resp_valid | input | 1 | A data packet response is present |
| resp_pid | input | 2 | Response data PID code |
| resp_err | input | 1 | Response damaged or timed out |
| resp_len | input | 11 | Response payload length in bytes |
| txn_accept | output | 1 | Response accepted (pulse) |
| txn_reject | output | 1 | Response rejected (pulse) |
| uframe_done | output | 1 | No more tokens this microframe (pulse) |
| cfg_err | output | 1 | Max-packet setting invalid |

## Verification
The bench builds the block with its default widths: an 11-bit payload field and a 2-bit count field. This reaches every count from one to three and every PID code, including MDATA. The payload limit is set to 100 bytes, so short, exact and oversize lengths sit one byte either side of the limit. Every invalid-count encoding and every reserved-bit case can also be reached with this setting.

// File: rtl/iso_seq_pkg.sv
package iso_seq_pkg;
  localparam logic [1:0] PID_D0 = 2'd0;
  localparam logic [1:0] PID_D1 = 2'd1;
  localparam logic [1:0] PID_D2 = 2'd2;
  localparam logic [1:0] PID_MD = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/iso_cfg_decode.sv
module iso_cfg_decode #(
  parameter int FIELD_W = 16,
  parameter int LEN_W   = 11,
  parameter int CNT_W   = 2
) (
  input  logic [FIELD_W-1:0] mps,
  output logic [LEN_W-1:0]   payload,
  output logic [CNT_W-1:0]   max_txn,
  output logic               cfg_bad
);
  localparam int RSV_W = FIELD_W - LEN_W - CNT_W;

  logic [CNT_W-1:0] extra;
  logic [RSV_W-1:0] rsv;

  assign payload = mps[LEN_W-1:0];
  assign extra   = mps[LEN_W+CNT_W-1:LEN_W];
  assign rsv     = mps[FIELD_W-1:LEN_W+CNT_W];
  assign max_txn = extra + CNT_W'(1);

  // the all-ones count encoding has no legal meaning
  assign cfg_bad = (|rsv) || (payload == '0) || (&extra);
endmodule

// File: rtl/iso_pid_judge.sv
module iso_pid_judge
  import iso_seq_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int CNT_W = 2
) (
  input  logic             first,
  input  logic [1:0]       exp_pid,
  input  logic [CNT_W-1:0] max_txn,
  input  logic [LEN_W-1:0] payload,
  input  logic [1:0]       pid,
  input  logic             err,
  input  logic [LEN_W-1:0] len,
  output logic             ok,
  output logic             more
);
  logic pid_ok;

  always_comb begin
    if (first) begin
      // first PID announces the count; it may not exceed the configured one
      pid_ok = (pid != PID_MD) && ({{(CNT_W > 2 ? CNT_W-2 : 0){1'b0}}, pid} < max_txn);
    end else begin
      pid_ok = (pid == exp_pid);
    end
    ok   = pid_ok && !err && (len <= payload);
    more = ok && (pid != PID_D0) && (len == payload);
  end
endmodule

// File: rtl/iso_in_uframe_seq.sv
module iso_in_uframe_seq
  import iso_seq_pkg::*;
#(
  parameter int FIELD_W = 16,
  parameter int LEN_W   = 11,
  parameter int CNT_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] mps_cfg,
  input  logic               uframe_start,
  output logic               token_valid,
  input  logic               token_ready,
  input  logic               resp_valid,
  input  logic [1:0]         resp_pid,
  input  logic               resp_err,
  input  logic [LEN_W-1:0]   resp_len,
  output logic               txn_accept,
  output logic               txn_reject,
  output logic               uframe_done,
  output logic               cfg_err
);
  seq_state_e       state_q;
  logic             first_q;
  logic [1:0]       exp_q;
  logic [LEN_W-1:0] payload_q;
  logic [CNT_W-1:0] max_q;

  logic [LEN_W-1:0] dec_payload;
  logic [CNT_W-1:0] dec_max;
  logic             judge_ok;
  logic             judge_more;

  iso_cfg_decode #(
    .FIELD_W(FIELD_W),
    .LEN_W  (LEN_W),
    .CNT_W  (CNT_W)
  ) i_cfg (
    .mps    (mps_cfg),
    .payload(dec_payload),
    .max_txn(dec_max),
    .cfg_bad(cfg_err)
  );

  iso_pid_judge #(
    .LEN_W(LEN_W),
    .CNT_W(CNT_W)
  ) i_judge (
    .first  (first_q),
    .exp_pid(exp_q),
    .max_txn(max_q),
    .payload(payload_q),
    .pid    (resp_pid),
    .err    (resp_err),
    .len    (resp_len),
    .ok     (judge_ok),
    .more   (judge_more)
  );

  assign token_valid = (state_q == ST_ISSUE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      first_q     <= 1'b1;
      exp_q       <= PID_D0;
      payload_q   <= '0;
      max_q       <= '0;
      txn_accept  <= 1'b0;
      txn_reject  <= 1'b0;
      uframe_done <= 1'b0;
    end else begin
      txn_accept  <= 1'b0;
      txn_reject  <= 1'b0;
      uframe_done <= 1'b0;
      if (uframe_start) begin
        if (cfg_err) begin
          state_q <= ST_IDLE;
        end else begin
          state_q   <= ST_ISSUE;
          first_q   <= 1'b1;
          payload_q <= dec_payload;
          max_q     <= dec_max;
        end
      end else begin
        case (state_q)
          ST_ISSUE: if (token_ready) state_q <= ST_WAIT;
          ST_WAIT: if (resp_valid) begin
            first_q <= 1'b0;
            exp_q   <= resp_pid - 2'd1;
            if (judge_ok) begin
              txn_accept <= 1'b1;
              if (judge_more) begin
                state_q <= ST_ISSUE;
              end else begin
                uframe_done <= 1'b1;
                state_q     <= ST_IDLE;
              end
            end else begin
              txn_reject  <= 1'b1;
              uframe_done <= 1'b1;
              state_q     <= ST_IDLE;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R1
  cfg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uframe_start && cfg_err |=> !token_valid);

  // R2
  start_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uframe_start && !cfg_err |=> token_valid);

  // R3
  token_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    token_valid && !token_ready && !uframe_start |=> token_valid);

  // R7
  d0_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_accept && ($past(resp_pid) == PID_D0) && !$past(uframe_start) |-> !token_valid);

  // R9
  continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_accept && !uframe_done |-> token_valid);

  // R10
  reject_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_reject && !$past(uframe_start) |-> !token_valid && uframe_done);

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(txn_accept && txn_reject));
endmodule

// File: tb/test_iso_in_uframe_seq.sv
module test_iso_in_uframe_seq;
  localparam int CLK_P = 10;
  localparam int NVEC  = 14;
  localparam logic [15:0] MPS1 = 16'h0064;
  localparam logic [15:0] MPS2 = 16'h0864;
  localparam logic [15:0] MPS3 = 16'h1064;

  // {mps, n responses, pid[2],pid[1],pid[0], lk[2],lk[1],lk[0], accept mask}
  // lk: 0 full, 1 short, 2 oversize, 3 error flag
  localparam logic [32:0] VEC [NVEC] = '{
    {MPS1, 2'd1, 6'b00_00_00, 6'b00_00_00, 3'b001}, // R4 R7
    {MPS2, 2'd2, 6'b00_00_01, 6'b00_00_00, 3'b011}, // R5 R9
    {MPS3, 2'd3, 6'b00_01_10, 6'b00_00_00, 3'b111}, // R5 R9 R7
    {MPS3, 2'd2, 6'b00_00_01, 6'b00_00_00, 3'b011}, // R4 fewer needed
    {MPS2, 2'd1, 6'b00_00_10, 6'b00_00_00, 3'b000}, // R4 too many
    {MPS1, 2'd1, 6'b00_00_01, 6'b00_00_00, 3'b000}, // R4 too many
    {MPS3, 2'd1, 6'b00_00_11, 6'b00_00_00, 3'b000}, // R4 MDATA
    {MPS3, 2'd2, 6'b00_00_10, 6'b00_00_00, 3'b001}, // R5 skipped step
    {MPS3, 2'd1, 6'b00_00_10, 6'b00_00_11, 3'b000}, // R6 error
    {MPS3, 2'd1, 6'b00_00_10, 6'b00_00_10, 3'b000}, // R6 oversize
    {MPS3, 2'd1, 6'b00_00_10, 6'b00_00_01, 3'b001}, // R8 short
    {MPS2, 2'd2, 6'b00_01_01, 6'b00_00_00, 3'b001}, // R5 repeat
    {MPS3, 2'd2, 6'b00_01_10, 6'b00_11_00, 3'b001}, // R6 R10
    {MPS3, 2'd3, 6'b00_01_10, 6'b01_00_00, 3'b111}  // R8 short DATA0
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mps_cfg = MPS3;
  logic        uframe_start = 1'b0;
  logic        token_valid;
  logic        token_ready = 1'b1;
  logic        resp_valid = 1'b0;
  logic [1:0]  resp_pid = 2'd0;
  logic        resp_err = 1'b0;
  logic [10:0] resp_len = 11'd0;
  logic        txn_accept, txn_reject, uframe_done, cfg_err;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  iso_in_uframe_seq i_iso_in_uframe_seq (
    .clk(clk), .rst_n(rst_n), .mps_cfg(mps_cfg), .uframe_start(uframe_start),
    .token_valid(token_valid), .token_ready(token_ready),
    .resp_valid(resp_valid), .resp_pid(resp_pid), .resp_err(resp_err),
    .resp_len(resp_len), .txn_accept(txn_accept), .txn_reject(txn_reject),
    .uframe_done(uframe_done), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_uf();
    @(negedge clk) uframe_start = 1'b1;
    @(negedge clk) uframe_start = 1'b0;
  endtask

  task automatic respond(input logic [1:0] pid, input logic [1:0] lk);
    logic [10:0] pay;
    pay = mps_cfg[10:0];
    @(negedge clk);
    resp_valid = 1'b1;
    resp_pid   = pid;
    resp_err   = (lk == 2'd3);
    resp_len   = (lk == 2'd1) ? pay - 11'd1 : (lk == 2'd2) ? pay + 11'd1 : pay;
    @(negedge clk);
    resp_valid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    check("R11 token_valid in reset", token_valid, 0);
    check("R11 pulses in reset", {txn_accept, txn_reject, uframe_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 token_valid after reset", token_valid, 0);
    check("R1 cfg_err for valid setting", cfg_err, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [32:0] e;
      int n;
      e = VEC[v];
      mps_cfg = e[32:17];
      n = int'(e[16:15]);
      start_uf();
      check($sformatf("R2 token after start v%0d", v), token_valid, 1);
      for (int t = 0; t < n; t++) begin
        logic acc;
        logic last;
        acc  = e[t];
        last = (t == n - 1);
        respond(e[9 + 2*t +: 2], e[3 + 2*t +: 2]);
        check($sformatf("R4 R5 R6 accept v%0d t%0d", v, t), txn_accept, int'(acc));
        check($sformatf("R11 reject v%0d t%0d", v, t), txn_reject, int'(!acc));
        check($sformatf("R7 R8 R10 done v%0d t%0d", v, t), uframe_done, int'(last));
        check($sformatf("R9 next token v%0d t%0d", v, t), token_valid, int'(!last));
      end
      @(negedge clk);
      check($sformatf("R11 pulse width v%0d", v), {txn_accept, txn_reject, uframe_done}, 0);
    end

    // R10 no token after a reject until next strobe
    mps_cfg = MPS2;
    start_uf();
    respond(2'd2, 2'd0);
    check("R10 reject", txn_reject, 1);
    repeat (4) @(negedge clk);
    check("R10 no retry token", token_valid, 0);

    // R3 hold without ready, stray response ignored
    mps_cfg = MPS3;
    token_ready = 1'b0;
    start_uf();
    repeat (3) @(negedge clk);
    check("R3 token held", token_valid, 1);
    resp_valid = 1'b1; resp_pid = 2'd2; resp_err = 1'b0; resp_len = 11'd100;
    @(negedge clk) resp_valid = 1'b0;
    check("R3 stray resp no accept", txn_accept, 0);
    check("R3 stray resp no reject", txn_reject, 0);
    check("R3 token still held", token_valid, 1);
    token_ready = 1'b1;
    @(negedge clk);
    check("R3 token taken", token_valid, 0);
    respond(2'd2, 2'd0);
    check("R3 accept after handshake", txn_accept, 1);

    // R2 restart mid-sequence: next response judged as first
    start_uf();
    check("R2 restart token", token_valid, 1);
    respond(2'd2, 2'd0);
    check("R2 DATA2 accepted as first", txn_accept, 1);
    respond(2'd1, 2'd1);
    check("R8 short DATA1 accept", txn_accept, 1);
    check("R8 short DATA1 done", uframe_done, 1);

    // R1 invalid settings block the strobe
    mps_cfg = 16'h2064;
    @(negedge clk);
    check("R1 reserved bit cfg_err", cfg_err, 1);
    start_uf();
    check("R1 reserved bit no token", token_valid, 0);
    mps_cfg = 16'h1864;
    @(negedge clk);
    check("R1 count 3 cfg_err", cfg_err, 1);
    start_uf();
    check("R1 count 3 no token", token_valid, 0);
    mps_cfg = 16'h1000;
    @(negedge clk);
    check("R1 zero payload cfg_err", cfg_err, 1);
    start_uf();
    check("R1 zero payload no token", token_valid, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule